// File: doc/BRIEF.md
# I2C Register Slave with Tuner Bus Gate

This block is a byte-oriented I2C slave that gives a host controller read and write access to a small bank of 8-bit configuration registers. Its 7-bit bus address is fixed in the upper five bits and completed by two strap inputs, so up to four instances can share one host bus. A register pointer is loaded by the first data byte of a write transfer. It then steps forward after every byte that is written or read, so a host can stream through consecutive registers in one transfer.

The block also bridges the host bus to a second, downstream bus that serves a tuner. When the gate is open, the tuner-side clock and data follow the host lines, and a low driven by the tuner on its data line is repeated back onto the host data line. A tuner can therefore acknowledge and return read data through the bridge. When the gate is closed, both tuner-side lines are released, so no host bus traffic reaches the tuner. Every line is modelled as open drain: the block sees a line level on an input and can only pull the line low through an output-enable.

Top module: `i2c_tuner_gate`

## Requirements
- R1: After reset no line is pulled low (`hsda_oe`, `tscl_oe` and `tsda_oe` are 0), the gate is closed and every register reads 0x00.
- R2: The slave acknowledges (pulls host SDA low in the ninth bit) only the address 0,0,0,1,0,`addr_strap[1]`,`addr_strap[0]`, MSB first, with the R/W bit last (0 = write, 1 = read). A transfer to any other address is not acknowledged and leaves every register unchanged.
- R3: In a write transfer, the first data byte loads the register pointer from its low log2(REG_COUNT) bits, and its upper bits are ignored. Each later byte is written to the register at the pointer and advances the pointer, which wraps from REG_COUNT-1 to 0. Every data byte is acknowledged.
- R4: In a read transfer, each byte returns the register at the pointer, MSB first, and advances the pointer. A master ACK (SDA low) in the ninth bit continues with the next register. A master NACK ends the transfer, and host SDA stays released.
- R5: The slave changes its own host SDA drive only while host SCL is low, so it never creates a START or STOP condition.
- R6: Bit 0 of register 0 requests the gate, with 1 meaning open. A change of this bit takes effect only at the next STOP condition on the host bus.
- R7: While the gate is open, the tuner SCL and SDA are pulled low whenever the host SCL and SDA, respectively, are low, and are released when they are high.
- R8: While the gate is open and the host is not holding SDA low, a low on tuner SDA pulls host SDA low. When the tuner releases SDA, both data lines return high and do not hold each other low.
- R9: While the gate is closed, both tuner lines stay released whatever the host does, and a low on tuner SDA has no effect on host SDA.
- R10: A START condition in the middle of a byte abandons that byte and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all bus lines are sampled with it |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_strap | input | 2 | Low two bits of the slave address |
| hscl_i | input | 1 | Host bus SCL line level |
| hsda_i | input | 1 | Host bus SDA line level |
| hsda_oe | output | 1 | Pull host SDA low when 1 |
| tsda_i | input | 1 | Tuner bus SDA line level |
| tscl_oe | output | 1 | Pull tuner SCL low when 1 |
| tsda_oe | output | 1 | Pull tuner SDA low when 1 |

## Verification
The bench builds the block with REG_COUNT = 4, so a two-byte burst crosses the pointer wrap. A pointer byte of 0x06 also shows that the upper pointer bits are dropped. HOLD_CYC and SYNC_STAGES keep their defaults, and the strap is tied to 2'b10, so addresses that differ only in a strap bit or only in the fixed upper bits can both be shown to be refused. The host bus runs at 100 ns per quarter bit, several times faster than 700 kbit/s, which puts the two-flop sampling lag and the gate hold-off window within a few cycles of the bus edges they must follow.

// File: rtl/i2cg_pkg.sv
// Shared types and constants for the I2C register slave with tuner gate.
// Assumes a 7-bit address whose upper five bits are fixed.
package i2cg_pkg;
    localparam logic [4:0] DEV_ADDR_HI = 5'b00010;
    localparam int         GATE_BIT    = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } slv_state_t;
endpackage

// File: rtl/i2cg_sync.sv
// Multi-stage synchroniser for asynchronous bus line levels.
// Assumes the lines idle high, so every stage resets to 1.
module i2cg_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the raw levels through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cg_regs.sv
// Bank of byte-wide configuration registers with one write port and one
// combinational read port. REG_COUNT must be a power of two.
module i2cg_regs #(
    parameter int REG_COUNT = 8,
    localparam int PTR_W    = $clog2(REG_COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             gate_req
);
    import i2cg_pkg::*;

    logic [7:0] mem [REG_COUNT];

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        // Hold one register, loaded when the write port addresses it
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= 8'h00;
            else if (wr_en && wr_idx == PTR_W'(g))
                mem[g] <= wr_data;
        end
    end

    assign rd_data  = mem[rd_idx];
    assign gate_req = mem[0][GATE_BIT];
endmodule

// File: rtl/i2cg_slave_fsm.sv
// I2C slave protocol engine. It detects START and STOP on the synchronised
// lines, matches the address, loads and advances the register pointer, and
// drives SDA for acknowledges and read data. It samples on SCL rising and
// changes its drive on SCL falling. It never stretches the clock.
module i2cg_slave_fsm #(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic [6:0]       dev_addr,
    input  logic [7:0]       rd_data,
    output logic [PTR_W-1:0] ptr,
    output logic             wr_en,
    output logic [7:0]       wr_data,
    output logic             sda_drive,
    output logic             stop_det
);
    import i2cg_pkg::*;

    slv_state_t state;
    logic       scl_d, sda_d;
    logic [3:0] cnt;
    logic [7:0] sh, tx;
    logic       rw, first, mack;
    logic       scl_rise, scl_fall, start_det;

    // Keep the previous line levels for edge and condition detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

    assign wr_en   = scl_fall && !start_det && !stop_det && state == ST_WDATA
                     && cnt == 4'd8 && !first;
    assign wr_data = sh;

    // Protocol sequencing: address, pointer, write data, read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= 4'd0;
            sh        <= 8'h00;
            tx        <= 8'h00;
            ptr       <= '0;
            sda_drive <= 1'b0;
            rw        <= 1'b0;
            first     <= 1'b0;
            mack      <= 1'b0;
        end else if (start_det) begin
            state     <= ST_ADDR;
            cnt       <= 4'd0;
            sda_drive <= 1'b0;
            first     <= 1'b1;
        end else if (stop_det) begin
            state     <= ST_IDLE;
            sda_drive <= 1'b0;
        end else if (scl_rise) begin
            case (state)
                ST_ADDR, ST_WDATA: begin
                    sh  <= {sh[6:0], sda_s};
                    cnt <= cnt + 4'd1;
                end
                ST_RACK: mack <= ~sda_s;
                default: ;
            endcase
        end else if (scl_fall) begin
            case (state)
                ST_ADDR: if (cnt == 4'd8) begin
                    if (sh[7:1] == dev_addr) begin
                        rw        <= sh[0];
                        state     <= ST_AACK;
                        sda_drive <= 1'b1;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_AACK: if (rw) begin
                    tx        <= rd_data;
                    sda_drive <= ~rd_data[7];
                    ptr       <= ptr + 1'b1;
                    cnt       <= 4'd0;
                    state     <= ST_RDATA;
                end else begin
                    sda_drive <= 1'b0;
                    cnt       <= 4'd0;
                    state     <= ST_WDATA;
                end
                ST_WDATA: if (cnt == 4'd8) begin
                    state     <= ST_WACK;
                    sda_drive <= 1'b1;
                    if (first) begin
                        ptr   <= sh[PTR_W-1:0];
                        first <= 1'b0;
                    end else begin
                        ptr <= ptr + 1'b1;
                    end
                end
                ST_WACK: begin
                    sda_drive <= 1'b0;
                    cnt       <= 4'd0;
                    state     <= ST_WDATA;
                end
                ST_RDATA: if (cnt == 4'd7) begin
                    sda_drive <= 1'b0;
                    state     <= ST_RACK;
                end else begin
                    tx        <= {tx[6:0], 1'b0};
                    sda_drive <= ~tx[6];
                    cnt       <= cnt + 4'd1;
                end
                ST_RACK: if (mack) begin
                    tx        <= rd_data;
                    sda_drive <= ~rd_data[7];
                    ptr       <= ptr + 1'b1;
                    cnt       <= 4'd0;
                    state     <= ST_RDATA;
                end else begin
                    state <= ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    // R5: the drive may change only on an edge that follows a low SCL sample
    a_r5_drive_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        $past(scl_s) |-> $stable(sda_drive));

    // R4: SDA is pulled only in acknowledge or read-data bits
    a_r4_drive_in_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive |-> (state inside {ST_AACK, ST_WACK, ST_RDATA}));
endmodule

// File: rtl/i2cg_gate.sv
// Bidirectional repeater between the host bus and the tuner bus. It opens
// or closes only at STOP. SCL is repeated one way, host to tuner. SDA is
// repeated in whichever direction pulled low first. After a release, a
// hold-off window blocks the echo of that release coming back through the
// synchroniser lag. Assumes HOLD_CYC is at least the synchroniser depth + 1.
module i2cg_gate #(
    parameter int HOLD_CYC = 4,
    localparam int HOLD_W  = $clog2(HOLD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_req,
    input  logic stop_det,
    input  logic hscl_s,
    input  logic hsda_s,
    input  logic tsda_s,
    output logic tscl_oe,
    output logic tsda_oe,
    output logic hsda_pull
);
    logic              gate_on;
    logic              fwd_h2t, fwd_t2h;
    logic [HOLD_W-1:0] hold_cnt;

    // Apply the requested gate state at STOP only
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_on <= 1'b0;
        else if (stop_det)
            gate_on <= gate_req;
    end

    // Decide which side owns the SDA low and time the hold-off window
    always_ff @(posedge clk) begin
        if (!rst_n || !gate_on) begin
            fwd_h2t  <= 1'b0;
            fwd_t2h  <= 1'b0;
            hold_cnt <= '0;
        end else begin
            if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
            if (fwd_h2t) begin
                if (hsda_s) begin
                    fwd_h2t  <= 1'b0;
                    hold_cnt <= HOLD_W'(HOLD_CYC);
                end
            end else if (fwd_t2h) begin
                if (tsda_s) begin
                    fwd_t2h  <= 1'b0;
                    hold_cnt <= HOLD_W'(HOLD_CYC);
                end
            end else if (hold_cnt == '0) begin
                if (!hsda_s)      fwd_h2t <= 1'b1;
                else if (!tsda_s) fwd_t2h <= 1'b1;
            end
        end
    end

    assign tscl_oe   = gate_on & ~hscl_s;
    assign tsda_oe   = gate_on & fwd_h2t;
    assign hsda_pull = gate_on & fwd_t2h;

    // R6: the gate state moves only on the cycle after a STOP
    a_r6_gate_moves_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on != $past(gate_on)) |-> $past(stop_det));

    // R8: SDA is never repeated both ways at once
    a_r8_single_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(tsda_oe && hsda_pull));

    // R9: a closed gate leaves both tuner lines released
    a_r9_closed_released: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(gate_on) && !gate_on |-> !tscl_oe && !tsda_oe && !hsda_pull);
endmodule

// File: rtl/i2c_tuner_gate.sv
// Top level: I2C register slave with a register-controlled tuner bus gate.
// Assumes open-drain pads outside; every output here means "pull low".
module i2c_tuner_gate #(
    parameter int REG_COUNT   = 8,
    parameter int HOLD_CYC    = 4,
    parameter int SYNC_STAGES = 2,
    localparam int PTR_W      = $clog2(REG_COUNT)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr_strap,
    input  logic       hscl_i,
    input  logic       hsda_i,
    output logic       hsda_oe,
    input  logic       tsda_i,
    output logic       tscl_oe,
    output logic       tsda_oe
);
    import i2cg_pkg::*;

    logic             hscl_s, hsda_s, tsda_s;
    logic [PTR_W-1:0] ptr;
    logic             wr_en, slv_drive, stop_det, gate_req, hsda_pull;
    logic [7:0]       wr_data, rd_data;

    i2cg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hscl_i, hsda_i, tsda_i}),
        .q     ({hscl_s, hsda_s, tsda_s})
    );

    i2cg_slave_fsm #(.PTR_W(PTR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (hscl_s),
        .sda_s     (hsda_s),
        .dev_addr  ({DEV_ADDR_HI, addr_strap}),
        .rd_data   (rd_data),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sda_drive (slv_drive),
        .stop_det  (stop_det)
    );

    i2cg_regs #(.REG_COUNT(REG_COUNT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (ptr),
        .wr_data  (wr_data),
        .rd_idx   (ptr),
        .rd_data  (rd_data),
        .gate_req (gate_req)
    );

    i2cg_gate #(.HOLD_CYC(HOLD_CYC)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_req  (gate_req),
        .stop_det  (stop_det),
        .hscl_s    (hscl_s),
        .hsda_s    (hsda_s),
        .tsda_s    (tsda_s),
        .tscl_oe   (tscl_oe),
        .tsda_oe   (tsda_oe),
        .hsda_pull (hsda_pull)
    );

    assign hsda_oe = slv_drive | hsda_pull;

    // R1: nothing is pulled low while reset is held
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> !tscl_oe && !tsda_oe);
endmodule

// File: tb/i2c_tuner_gate_test.sv
module i2c_tuner_gate_test;
    localparam int         Q     = 20;
    localparam logic [1:0] STRAP = 2'b10;
    localparam logic [6:0] MYADR = {5'b00010, STRAP};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1, tun_pull = 1'b0;
    logic hsda_oe, tscl_oe, tsda_oe;
    logic host_scl, host_sda, tuner_scl, tuner_sda;
    int   checks = 0, failures = 0, viol = 0;
    logic done = 1'b0;
    logic [7:0] exp_regs [4];

    always #2.5 clk = ~clk;

    assign host_scl  = m_scl;
    assign host_sda  = m_sda & ~hsda_oe;
    assign tuner_scl = ~tscl_oe;
    assign tuner_sda = ~(tsda_oe | tun_pull);

    i2c_tuner_gate #(.REG_COUNT(4)) uut (
        .clk(clk), .rst_n(rst_n), .addr_strap(STRAP),
        .hscl_i(host_scl), .hsda_i(host_sda), .hsda_oe(hsda_oe),
        .tsda_i(tuner_sda), .tscl_oe(tscl_oe), .tsda_oe(tsda_oe)
    );

    // address, register index, data
    localparam logic [16:0] VEC [7] = '{
        {7'h0A, 2'd1, 8'h3C}, {7'h0A, 2'd3, 8'hF0}, {7'h0B, 2'd2, 8'h11},
        {7'h4A, 2'd2, 8'h22}, {7'h0A, 2'd2, 8'h81}, {7'h08, 2'd1, 8'h55},
        {7'h0A, 2'd1, 8'h00}};

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic i2c_start;
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop;
        m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(2*Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
        b = host_sda; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic rbyte(output logic [7:0] d, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
        send_bit(~ack);
    endtask

    task automatic rd_reg(input logic [7:0] idx, output logic [7:0] v);
        logic a;
        i2c_start; wbyte({MYADR, 1'b0}, a); wbyte(idx, a);
        i2c_start; wbyte({MYADR, 1'b1}, a); rbyte(v, 1'b0); i2c_stop;
    endtask

    // R5 monitor: the slave drive must not move while SCL stays high
    logic prev_scl = 1'b1, prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n && host_scl && prev_scl && hsda_oe != prev_oe) viol++;
        prev_scl = host_scl;
        prev_oe  = hsda_oe;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] v;
        for (int i = 0; i < 4; i++) exp_regs[i] = 8'h00;
        tick(5);
        chk("R1 hsda_oe", hsda_oe, 0);
        chk("R1 tscl_oe", tscl_oe, 0);
        chk("R1 tsda_oe", tsda_oe, 0);
        rst_n = 1'b1;
        tick(10);
        rd_reg(8'd3, v); chk("R1 reg3 reset", v, 8'h00);

        // Table walk: write through the given address, read back through ours
        for (int i = 0; i < 7; i++) begin
            logic [6:0] ad;
            logic [1:0] ix;
            logic [7:0] dt;
            {ad, ix, dt} = VEC[i];
            i2c_start; wbyte({ad, 1'b0}, a);
            chk("R2 address ack", a, ad == MYADR);
            wbyte({6'd0, ix}, a); wbyte(dt, a); i2c_stop;
            if (ad == MYADR) exp_regs[ix] = dt;
            rd_reg({6'd0, ix}, v);
            chk("R2 R3 readback", v, exp_regs[ix]);
        end

        // R3 burst write across the pointer wrap
        i2c_start; wbyte({MYADR, 1'b0}, a); wbyte(8'h03, a);
        wbyte(8'h11, a); chk("R3 data ack", a, 1);
        wbyte(8'h22, a); i2c_stop;
        exp_regs[3] = 8'h11; exp_regs[0] = 8'h22;
        // R4 burst read with ACK, ACK, NACK
        i2c_start; wbyte({MYADR, 1'b0}, a); wbyte(8'h03, a);
        i2c_start; wbyte({MYADR, 1'b1}, a);
        rbyte(v, 1'b1); chk("R4 read first", v, exp_regs[3]);
        rbyte(v, 1'b1); chk("R4 read wrapped", v, exp_regs[0]);
        rbyte(v, 1'b0); chk("R4 read third", v, exp_regs[1]);
        tick(4); chk("R4 sda released after NACK", hsda_oe, 0);
        i2c_stop;
        // R3 pointer byte upper bits ignored: 0x06 selects register 2
        rd_reg(8'h06, v); chk("R3 pointer low bits", v, exp_regs[2]);

        // R6 gate opens only at STOP
        i2c_start; wbyte({MYADR, 1'b0}, a); wbyte(8'h00, a); wbyte(8'h01, a);
        tick(4); chk("R6 gate not yet open", tscl_oe, 0);
        i2c_stop; tick(4);
        i2c_start; tick(5);
        chk("R7 tuner scl follows low", tuner_scl, 0);
        chk("R7 tuner sda follows low", tuner_sda, 0);
        m_sda = 1'b1; tick(8);
        chk("R7 tuner sda follows release", tuner_sda, 1);
        tun_pull = 1'b1; tick(8);
        chk("R8 tuner low reflected", host_sda, 0);
        tun_pull = 1'b0; tick(12);
        chk("R8 host sda returns high", host_sda, 1);
        chk("R8 tuner sda returns high", tuner_sda, 1);
        i2c_stop;
        rd_reg(8'd0, v); chk("R6 gate bit readback", v, 8'h01);

        // R6 closing also waits for STOP
        i2c_start; wbyte({MYADR, 1'b0}, a); wbyte(8'h00, a); wbyte(8'h00, a);
        tick(4); chk("R6 gate still open before STOP", tscl_oe, 1);
        i2c_stop; tick(4);
        i2c_start; m_sda = 1'b1; tick(8);
        chk("R9 tuner scl released", tuner_scl, 1);
        tun_pull = 1'b1; tick(8);
        chk("R9 tuner low not reflected", host_sda, 1);
        chk("R9 tuner sda not driven", tsda_oe, 0);
        tun_pull = 1'b0; tick(4);
        i2c_stop;

        // R10 repeated START in the middle of a byte
        i2c_start; send_bit(1); send_bit(0); send_bit(1); send_bit(1);
        i2c_start; wbyte({MYADR, 1'b0}, a);
        chk("R10 address after restart", a, 1);
        wbyte(8'h02, a); wbyte(8'h5A, a); i2c_stop;
        exp_regs[2] = 8'h5A;
        rd_reg(8'd2, v); chk("R10 write after restart", v, 8'h5A);

        chk("R5 drive changes with SCL high", viol, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule